// File: doc/BRIEF.md
# Fractional-N Quad-Modulus Feedback Divider

This block models the feedback divider of a fractional-N synthesizer whose front end is a four-modulus prescaler. Every rising edge of `clk_i` stands for one input (oscillator) cycle. The block groups these edges into prescaler cycles of P, P+1, P+4 or P+5 edges. P is 8 in cellular mode and 16 in high-band mode. After C prescaler cycles it emits a single feedback pulse, so the integer divide ratio N comes out exactly.

A fractional accumulator adds the numerator once per feedback period, modulo the denominator. On each wrap it lengthens the period that is starting by one input cycle, which gives an average ratio of N + num/den. The divide word is split and checked at each period boundary. A legal word is taken for the coming period. An illegal word is refused: the previous setting keeps running and an error flag is raised.

Top module: `fracn_quad_div`

## Requirements
- R1: The prescaler modulus base is 8 when `pcs_mode_i`=0 and 16 when it is 1. Integer words are split as C = N div P, B = (N − C·P) div 4, A = (N − C·P) mod 4. Cycle k of a period (k from 0) lasts P + [k<A] + 4·[k<B] edges. With no fraction, the spacing between feedback pulses is exactly N edges in both modes.
- R2: A word is legal only if C ≥ 3 and C ≥ max(A,B)+2. So 80 is accepted in high-band mode and 79 is refused, while 40 is accepted in cellular mode and 39 is refused.
- R3: In cellular mode the word may not exceed 16383: 16383 is accepted and 16384 is refused. In high-band mode the full 15-bit range is subject only to R2.
- R4: `frac_den_i` code 0 means a denominator of 16 and codes 9 to 15 mean themselves. Codes 1 to 8 are refused, and so is any numerator not smaller than the denominator.
- R5: At each period boundary the accumulator adds the numerator. When the sum reaches the denominator, it subtracts the denominator and the starting period is N+1 edges. Over any 2·den consecutive periods, the total equals 2·den·N + 2·num edges.
- R6: With a numerator of 0, every period is exactly N edges.
- R7: With `frac_byp_i`=1 the numerator has no effect: every period is N edges and the accumulator is held at zero.
- R8: A refused word does not change the running setting. The old period length continues and `word_err_o` is 1 from that boundary until a legal word is taken, which clears it.
- R9: Inputs are sampled only at a period boundary (a feedback pulse). A change made inside a period leaves that period unchanged and takes effect in the next one.
- R10: During and after reset, `fb_pulse_o` and `word_err_o` are 0. The first clock edge after reset loads the word. If that word is illegal, no pulse appears, `word_err_o` is 1, and loading is retried on every edge.
- R11: `fb_pulse_o` is high for exactly one clock per period.
- R12: When a new denominator is taken, the accumulator restarts from zero before the numerator is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input cycle clock (one edge per oscillator cycle) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| n_word_i | input | 15 | Integer divide ratio N |
| frac_num_i | input | 4 | Fractional numerator |
| frac_den_i | input | 4 | Denominator code (0 = 16, 9..15 literal) |
| pcs_mode_i | input | 1 | 1 = modulus base 16, 0 = modulus base 8 |
| frac_byp_i | input | 1 | 1 = fraction ignored, accumulator held at zero |
| fb_pulse_o | output | 1 | One-cycle pulse at the end of each divide period |
| word_err_o | output | 1 | Last word offered at a boundary was refused |

## Verification
The hardest case to reach from the ports is a denominator change that happens while the accumulator holds a non-zero residue. Only the length of the periods that follow can show whether that residue was cleared. The stimulus runs a numerator of 4 over 16 for six periods, which leaves a residue of 8. At a boundary it then switches to a denominator of 9. With the residue kept, the first new period would overflow at once; with it cleared, the first overflow comes only at the third period. Refused words are applied straight after an observed pulse, so the bench knows exactly which boundary samples them.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  parameter int unsigned N_W    = 15;
  parameter int unsigned FRAC_W = 4;

  localparam int unsigned C_W      = N_W - 3;
  localparam int unsigned DEN_W    = FRAC_W + 1;
  localparam int unsigned DEN_FULL = 1 << FRAC_W;
  localparam int unsigned DEN_MIN  = (1 << (FRAC_W - 1)) + 1;
  localparam int unsigned MOD_W    = 5;
  localparam int unsigned P_CELL   = 8;
  localparam int unsigned P_PCS    = 16;
  localparam int unsigned C_MIN    = 3;
  localparam int unsigned C_MARGIN = 2;

  typedef struct packed {
    logic [C_W-1:0]    c;
    logic [1:0]        b;
    logic [1:0]        a;
    logic              pcs;
    logic [DEN_W-1:0]  den;
    logic [FRAC_W-1:0] num;
    logic              byp;
  } div_cfg_t;

  // edges in prescaler cycle idx of a period
  function automatic logic [MOD_W-1:0] presc_mod(input logic pcs, input logic [C_W-1:0] idx,
                                                 input logic [1:0] a, input logic [1:0] b,
                                                 input logic extra);
    logic [MOD_W-1:0] m;
    m = pcs ? MOD_W'(P_PCS) : MOD_W'(P_CELL);
    if (idx < C_W'(a)) m = m + MOD_W'(1);
    if (idx < C_W'(b)) m = m + MOD_W'(4);
    if (extra && idx == '0) m = m + MOD_W'(1);
    return m;
  endfunction
endpackage

// File: rtl/fracn_word_dec.sv
module fracn_word_dec
  import fracn_pkg::*;
(
  input  logic [N_W-1:0]    n_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_code_i,
  input  logic              pcs_i,
  input  logic              byp_i,
  output div_cfg_t          cfg_o,
  output logic              legal_o
);
  logic [C_W-1:0]   c_w;
  logic [3:0]       rem;
  logic [1:0]       mx;
  logic [DEN_W-1:0] den_w;
  logic             c_ok, range_ok, den_ok, num_ok;

  always_comb begin
    if (pcs_i) begin
      c_w = C_W'(n_i >> 4);
      rem = n_i[3:0];
    end else begin
      c_w = C_W'(n_i >> 3);
      rem = {1'b0, n_i[2:0]};
    end
    mx       = (rem[1:0] > rem[3:2]) ? rem[1:0] : rem[3:2];
    c_ok     = (c_w >= C_W'(C_MIN)) && (c_w >= C_W'(mx) + C_W'(C_MARGIN));
    range_ok = pcs_i || !n_i[N_W-1];
    den_ok   = (den_code_i == '0) || (den_code_i >= FRAC_W'(DEN_MIN));
    den_w    = (den_code_i == '0) ? DEN_W'(DEN_FULL) : {1'b0, den_code_i};
    num_ok   = DEN_W'(num_i) < den_w;
    legal_o  = c_ok && range_ok && den_ok && num_ok;

    cfg_o.c   = c_w;
    cfg_o.b   = rem[3:2];
    cfg_o.a   = rem[1:0];
    cfg_o.pcs = pcs_i;
    cfg_o.den = den_w;
    cfg_o.num = num_i;
    cfg_o.byp = byp_i;
  end
endmodule

// File: rtl/fracn_frac_acc.sv
module fracn_frac_acc
  import fracn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [DEN_W-1:0]  den_i,
  input  logic              byp_i,
  output logic              carry_o,
  output logic [FRAC_W-1:0] acc_o
);
  logic [DEN_W-1:0]  den_q, sum;
  logic [FRAC_W-1:0] acc_q, base;

  always_comb begin
    // new denominator restarts the residue
    base    = (den_i != den_q) ? '0 : acc_q;
    sum     = DEN_W'(base) + DEN_W'(num_i);
    carry_o = !byp_i && (sum >= den_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      den_q <= '0;
      acc_q <= '0;
    end else if (step_i) begin
      den_q <= den_i;
      if (byp_i)        acc_q <= '0;
      else if (carry_o) acc_q <= FRAC_W'(sum - den_i);
      else              acc_q <= FRAC_W'(sum);
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fracn_presc_seq.sv
module fracn_presc_seq
  import fracn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             extra_i,
  input  div_cfg_t         ld_cfg_i,
  input  div_cfg_t         cur_cfg_i,
  output logic             end_o,
  output logic [MOD_W-1:0] pre_o
);
  logic [MOD_W-1:0] pre_q;
  logic [C_W-1:0]   idx_q;
  logic             last;

  assign last  = (idx_q == cur_cfg_i.c - C_W'(1));
  assign end_o = run_i && (pre_q == '0) && last;
  assign pre_o = pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      pre_q <= presc_mod(ld_cfg_i.pcs, '0, ld_cfg_i.a, ld_cfg_i.b, extra_i) - MOD_W'(1);
    end else if (run_i) begin
      if (pre_q == '0) begin
        if (!last) begin
          idx_q <= idx_q + C_W'(1);
          pre_q <= presc_mod(cur_cfg_i.pcs, idx_q + C_W'(1), cur_cfg_i.a, cur_cfg_i.b, 1'b0)
                   - MOD_W'(1);
        end
      end else begin
        pre_q <= pre_q - MOD_W'(1);
      end
    end
  end
endmodule

// File: rtl/fracn_quad_div.sv
module fracn_quad_div
  import fracn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_W-1:0]    n_word_i,
  input  logic [FRAC_W-1:0] frac_num_i,
  input  logic [FRAC_W-1:0] frac_den_i,
  input  logic              pcs_mode_i,
  input  logic              frac_byp_i,
  output logic              fb_pulse_o,
  output logic              word_err_o
);
  div_cfg_t         dec_cfg, cfg_q, cfg_sel;
  logic             legal, run_q, seq_end, boundary, load, carry;
  logic             pulse_q, err_q;
  logic [FRAC_W-1:0] acc_w;
  logic [MOD_W-1:0]  pre_w;

  fracn_word_dec u_dec (
    .n_i        (n_word_i),
    .num_i      (frac_num_i),
    .den_code_i (frac_den_i),
    .pcs_i      (pcs_mode_i),
    .byp_i      (frac_byp_i),
    .cfg_o      (dec_cfg),
    .legal_o    (legal)
  );

  // before first legal load every edge is a retry
  assign boundary = !run_q || seq_end;
  assign load     = boundary && (legal || run_q);
  assign cfg_sel  = legal ? dec_cfg : cfg_q;

  fracn_frac_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (load),
    .num_i   (cfg_sel.num),
    .den_i   (cfg_sel.den),
    .byp_i   (cfg_sel.byp),
    .carry_o (carry),
    .acc_o   (acc_w)
  );

  fracn_presc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .load_i    (load),
    .extra_i   (carry),
    .ld_cfg_i  (cfg_sel),
    .cur_cfg_i (cfg_q),
    .end_o     (seq_end),
    .pre_o     (pre_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= seq_end;
      if (boundary) err_q <= !legal;
      if (load) begin
        cfg_q <= cfg_sel;
        run_q <= 1'b1;
      end
    end
  end

  assign fb_pulse_o = pulse_q;
  assign word_err_o = err_q;
endmodule

// File: rtl/fracn_quad_div_chk.sv
module fracn_quad_div_chk
  import fracn_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fb_pulse_o,
  input logic              word_err_o,
  input logic              run_q,
  input div_cfg_t          cfg_q,
  input logic [FRAC_W-1:0] acc,
  input logic [MOD_W-1:0]  pre_cnt
);
  logic [1:0] mx;
  assign mx = (cfg_q.a > cfg_q.b) ? cfg_q.a : cfg_q.b;

  // R11
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  // R10
  idle_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_q) |-> !fb_pulse_o);

  // R8
  err_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$stable(word_err_o)) |-> fb_pulse_o);

  // R2
  legal_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cfg_q.c >= C_W'(C_MIN) && cfg_q.c >= C_W'(mx) + C_W'(C_MARGIN)));

  // R1
  presc_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pre_cnt < (cfg_q.pcs ? MOD_W'(P_PCS + 6) : MOD_W'(P_CELL + 6))));

  // R5
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (DEN_W'(acc) < cfg_q.den));

  // R7
  byp_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cfg_q.byp) |-> (acc == '0));
endmodule

bind fracn_quad_div fracn_quad_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fb_pulse_o (fb_pulse_o),
  .word_err_o (word_err_o),
  .run_q      (run_q),
  .cfg_q      (cfg_q),
  .acc        (acc_w),
  .pre_cnt    (pre_w)
);

// File: tb/fracn_quad_div_tb.sv
module fracn_quad_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] n_word_i = 15'd100;
  logic [3:0]  frac_num_i = 4'd0;
  logic [3:0]  frac_den_i = 4'd0;
  logic        pcs_mode_i = 1'b1;
  logic        frac_byp_i = 1'b0;
  logic        fb_pulse_o, word_err_o;

  int checks = 0, errors = 0;
  int cyc = 0, last_pc = 0, last_gap = 0, pulse_cnt = 0;

  fracn_quad_div u_dut (
    .clk_i, .rst_ni, .n_word_i, .frac_num_i, .frac_den_i,
    .pcs_mode_i, .frac_byp_i, .fb_pulse_o, .word_err_o
  );

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    if (fb_pulse_o) begin
      last_gap  = cyc - last_pc;
      last_pc   = cyc;
      pulse_cnt = pulse_cnt + 1;
    end
    if (cyc >= 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ovf_at(input int m, input int num, input int den);
    return (m * num) / den - ((m - 1) * num) / den;
  endfunction

  task automatic next_gap(output int g);
    int c;
    c = pulse_cnt;
    wait (pulse_cnt != c);
    g = last_gap;
  endtask

  task automatic set_word(input int n, input int num, input int dc, input bit pcs, input bit byp);
    n_word_i   = 15'(n);
    frac_num_i = 4'(num);
    frac_den_i = 4'(dc);
    pcs_mode_i = pcs;
    frac_byp_i = byp;
  endtask

  task automatic fresh(input int n, input int num, input int dc, input bit pcs, input bit byp);
    int g;
    set_word(n, num, dc, pcs, byp);
    @(negedge clk_i) rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    next_gap(g);
  endtask

  task automatic t_reset();
    set_word(100, 0, 0, 1'b1, 1'b0);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(fb_pulse_o == 1'b0, "R10 pulse in reset", fb_pulse_o, 0);
    chk(word_err_o == 1'b0, "R10 err in reset", word_err_o, 0);
  endtask

  task automatic t_integer(input int n, input bit pcs);
    int g;
    fresh(n, 0, 0, pcs, 1'b0);
    @(negedge clk_i);
    chk(fb_pulse_o == 1'b0, "R11 pulse width", fb_pulse_o, 0);
    for (int k = 0; k < 3; k++) begin
      next_gap(g);
      chk(g == n, "R1 R6 integer period", g, n);
    end
    chk(word_err_o == 1'b0, "R2 R3 legal word", word_err_o, 0);
  endtask

  task automatic t_frac(input int n, input int num, input int dc, input bit pcs);
    int g, den, total, kk, e;
    den = (dc == 0) ? 16 : dc;
    fresh(n, num, dc, pcs, 1'b0);
    total = 0;
    kk = 2 * den;
    for (int j = 2; j <= kk + 1; j++) begin
      next_gap(g);
      e = n + ovf_at(j, num, den);
      chk(g == e, "R5 R4 fractional period", g, e);
      total += g;
    end
    chk(total * den == kk * (n * den + num), "R5 average", total, kk * n + 2 * num);
  endtask

  task automatic t_bypass();
    int g;
    fresh(100, 5, 0, 1'b1, 1'b1);
    for (int k = 0; k < 20; k++) begin
      next_gap(g);
      chk(g == 100, "R7 bypass period", g, 100);
    end
  endtask

  task automatic t_bad_start();
    int c, g;
    set_word(79, 0, 0, 1'b1, 1'b0);
    @(negedge clk_i) rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    c = pulse_cnt;
    repeat (200) @(negedge clk_i);
    chk(pulse_cnt == c, "R10 R2 no pulse on illegal start", pulse_cnt - c, 0);
    chk(word_err_o == 1'b1, "R10 R2 err on illegal start", word_err_o, 1);
    set_word(80, 0, 0, 1'b1, 1'b0);
    next_gap(g);
    chk(word_err_o == 1'b0, "R2 err cleared at 80", word_err_o, 0);
    next_gap(g);
    chk(g == 80, "R2 period 80", g, 80);
  endtask

  task automatic t_reject(input int n, input int num, input int dc, input bit pcs, input string req);
    int g;
    fresh(100, 0, 0, 1'b1, 1'b0);
    set_word(n, num, dc, pcs, 1'b0);
    next_gap(g);
    chk(g == 100, {req, " R9 old period"}, g, 100);
    chk(word_err_o == 1'b1, {req, " R8 err set"}, word_err_o, 1);
    next_gap(g);
    chk(g == 100, {req, " R8 setting kept"}, g, 100);
    chk(word_err_o == 1'b1, {req, " R8 err held"}, word_err_o, 1);
    set_word(100, 0, 0, 1'b1, 1'b0);
    next_gap(g);
    chk(word_err_o == 1'b0, {req, " R8 err cleared"}, word_err_o, 0);
    next_gap(g);
    chk(g == 100, {req, " R8 restored"}, g, 100);
  endtask

  task automatic t_retune();
    int g;
    fresh(100, 0, 0, 1'b1, 1'b0);
    repeat (30) @(negedge clk_i);
    set_word(120, 0, 0, 1'b1, 1'b0);
    next_gap(g);
    chk(g == 100, "R9 mid-period change ignored", g, 100);
    next_gap(g);
    chk(g == 120, "R9 new word next period", g, 120);
  endtask

  task automatic t_den_change();
    int g, e;
    fresh(100, 4, 0, 1'b1, 1'b0);
    for (int j = 2; j <= 5; j++) begin
      next_gap(g);
      e = 100 + ovf_at(j, 4, 16);
      chk(g == e, "R12 before change", g, e);
    end
    set_word(100, 4, 9, 1'b1, 1'b0);
    next_gap(g);
    e = 100 + ovf_at(6, 4, 16);
    chk(g == e, "R12 last old period", g, e);
    for (int m = 1; m <= 9; m++) begin
      next_gap(g);
      e = 100 + ovf_at(m, 4, 9);
      chk(g == e, "R12 restart after den change", g, e);
    end
  endtask

  initial begin
    t_reset();
    t_integer(100, 1'b1);
    t_integer(80, 1'b1);
    t_integer(40, 1'b0);
    t_integer(77, 1'b0);
    t_integer(16383, 1'b0);
    t_frac(100, 7, 0, 1'b1);
    t_frac(45, 8, 9, 1'b0);
    t_frac(200, 14, 15, 1'b1);
    t_bypass();
    t_bad_start();
    t_reject(79, 0, 0, 1'b1, "R2 pcs 79");
    t_reject(39, 0, 0, 1'b0, "R2 cell 39");
    t_reject(16384, 0, 0, 1'b0, "R3 cell 16384");
    t_reject(100, 0, 4, 1'b1, "R4 den code 4");
    t_reject(100, 10, 9, 1'b1, "R4 num over den");
    t_retune();
    t_den_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule